// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is one channel of a scatter-gather DMA engine. Software loads the address of the first descriptor into a two-word pointer register and then writes the control/status register to launch the channel. The walker then works through a linked list of 32-byte descriptors held in host memory. It reads each descriptor one 32-bit word at a time over a simple request/acknowledge read port. For each descriptor it hands one transfer command (buffer address, byte count, direction) to a downstream data mover and waits for that command to be acknowledged. It then follows the link word to the next descriptor.

The link word does two jobs. Its low five bits carry per-descriptor flags: end of chain, interrupt on completion and direction. The rest of the word, together with the high link word, is the 32-byte-aligned address of the next descriptor. A chain whose last link points back to an earlier descriptor and has no end flag forms a ring. A ring runs until software aborts it. An abort lets the transfer command already in flight finish and stops at the next descriptor boundary. A bytes-transferred register adds up the acknowledged counts. A sticky interrupt bit, cleared by writing 1, drives a level interrupt pin.

Register words are selected by `cfg_sel`. Index 0 is the descriptor pointer low word and index 1 is the pointer high word (byte offset +4). Index 2 is control/status and index 3 is bytes transferred.

Top module: `sgdma_walker`

## Requirements
- R1: A write to control/status (index 2) launches the channel only when enable (bit 0), start (bit 1) and scatter-gather mode (bit 8) are all set in the data and the channel is idle. Done (bit 4) then reads 0 until the walk ends. A launch write without bit 8 does nothing.
- R2: Each descriptor is read as eight word reads at byte offsets 0, 4, ..., 28 from its address, in increasing order. Word 0 is the buffer address low, word 1 the buffer address high, word 4 the byte count, word 6 the link low and word 7 the link high. The first descriptor address is {pointer high, pointer low with bits 4:0 cleared}.
- R3: A descriptor with a nonzero count issues exactly one command. The command carries mv_addr = {word 1, word 0}, mv_len = word 4 and mv_to_host = bit 3 of word 6 (1 = toward host). mv_valid and the command fields stay stable until mv_ack.
- R4: The next descriptor address is {word 7, word 6 with bits 4:0 cleared}. The flag bits and any other bits in 4:0 do not affect it.
- R5: When bit 1 of word 6 (end of chain) is set, the walk stops after that descriptor and done reads 1.
- R6: A descriptor whose count is zero issues no command, and the walk continues to its link.
- R7: The bytes register (index 3) is cleared by a launch and adds mv_len on each acknowledged command.
- R8: When a descriptor completes with bit 2 of word 6 set, control/status bit 5 and the irq pin become 1. Writing 1 to bit 5 clears both.
- R9: A chain whose last link points back to an earlier descriptor and has no end flag keeps cycling with no limit.
- R10: Writing bit 2 (abort) to control/status while busy lets an issued command complete, issues no further command and then sets done.
- R11: After reset the channel is idle: done reads 1, the interrupt bit, the irq pin and the bytes register read 0, and mem_req and mv_valid are 0.
- R12: A launch write while the channel is busy is ignored. It does not clear the bytes register and does not restart the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register word index (0 ptr low, 1 ptr high, 2 control/status, 3 bytes) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register selected by cfg_sel |
| mem_req | output | 1 | Descriptor word read request, held until mem_ack |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid in this cycle |
| mem_rdata | input | 32 | Descriptor word read data |
| mv_valid | output | 1 | Transfer command valid, held until mv_ack |
| mv_addr | output | ADDR_W | Transfer buffer address |
| mv_len | output | 32 | Transfer byte count |
| mv_to_host | output | 1 | 1 = data moves toward the host bus |
| mv_ack | input | 1 | Transfer completion acknowledge |
| irq | output | 1 | Level interrupt, high while the interrupt bit is set |

## Verification
The in-RTL properties check on every cycle that word reads and transfer commands hold steady until acknowledged and that reads advance in 4-byte steps. They also check that no command overlaps a descriptor fetch, that end-of-chain and a pending abort always return the walker to idle at the boundary, that a launch clears the byte total, and that the interrupt bit only rises after a completion event. Only the bench's scenarios can show the rest. These are the exact command contents, the masking of the link flags out of the next address, the skipping of zero-count descriptors, the indefinite cycling of a ring, the ignoring of a launch while busy, and the sum in the bytes register at the end of a walk.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int DESC_WORDS  = 8;
   localparam int W_BUF_LO    = 0;
   localparam int W_BUF_HI    = 1;
   localparam int W_COUNT     = 4;
   localparam int W_LINK_LO   = 6;
   localparam int W_LINK_HI   = 7;
   localparam int LINK_ALIGN  = 5;
   localparam int LF_LAST     = 1;
   localparam int LF_IRQ      = 2;
   localparam int LF_TOHOST   = 3;
   localparam int CS_EN       = 0;
   localparam int CS_GO       = 1;
   localparam int CS_STOP     = 2;
   localparam int CS_IDLE     = 4;
   localparam int CS_IRQ      = 5;
   localparam int CS_SG       = 8;
   localparam logic [1:0] SEL_PTR_LO = 2'd0;
   localparam logic [1:0] SEL_PTR_HI = 2'd1;
   localparam logic [1:0] SEL_CSR    = 2'd2;
   localparam logic [1:0] SEL_BYTES  = 2'd3;

   typedef struct packed {
      logic [31:0] buf_lo;
      logic [31:0] buf_hi;
      logic [31:0] count;
      logic [31:0] link_lo;
      logic [31:0] link_hi;
   } sgd_desc_t;

   typedef enum logic [1:0] {
      WK_IDLE,
      WK_FETCH,
      WK_MOVE,
      WK_STEP
   } wk_state_t;
endpackage

// File: rtl/sgd_fetch.sv
module sgd_fetch
   import sgd_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output sgd_desc_t         desc_o
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   logic [IDX_W-1:0]  idx_q;
   logic              busy_q;
   logic              done_q;
   logic [ADDR_W-1:0] base_q;
   sgd_desc_t         desc_q;
   logic              take;

   assign take       = busy_q && mem_ack_i;
   assign mem_req_o  = busy_q;
   assign mem_addr_o = base_q + ADDR_W'({idx_q, 2'b00});
   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign desc_o     = desc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         base_q <= '0;
      end else begin
         done_q <= take && (idx_q == IDX_LAST);
         if (go_i && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            base_q <= base_i;
         end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_q <= '0;
      end else if (take) begin
         if (idx_q == IDX_W'(W_BUF_LO))  desc_q.buf_lo  <= mem_rdata_i;
         if (idx_q == IDX_W'(W_BUF_HI))  desc_q.buf_hi  <= mem_rdata_i;
         if (idx_q == IDX_W'(W_COUNT))   desc_q.count   <= mem_rdata_i;
         if (idx_q == IDX_W'(W_LINK_LO)) desc_q.link_lo <= mem_rdata_i;
         if (idx_q == IDX_W'(W_LINK_HI)) desc_q.link_hi <= mem_rdata_i;
      end
   end

   // R2: a pending word read keeps its address until acknowledged
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R2: consecutive words of one descriptor are 4 bytes apart
   p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && idx_q != IDX_LAST) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
   import sgd_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic [ADDR_W-1:0] head_i,
   input  logic              abort_i,
   output logic              busy_o,
   output logic              fetch_go_o,
   output logic [ADDR_W-1:0] fetch_base_o,
   input  logic              fetch_busy_i,
   input  logic              fetch_done_i,
   input  sgd_desc_t         desc_i,
   output logic              mv_valid_o,
   output logic [ADDR_W-1:0] mv_addr_o,
   output logic [31:0]       mv_len_o,
   output logic              mv_to_host_o,
   input  logic              mv_ack_i,
   output logic              irq_evt_o,
   output logic              credit_o,
   output logic [CNT_W-1:0]  credit_len_o
);
   wk_state_t         state_q;
   logic              abort_q;
   logic              cut_q;
   logic [ADDR_W-1:0] buf_addr;
   logic [ADDR_W-1:0] link_addr;
   logic [31:0]       link_lo_al;
   logic              last_link;
   logic              go_on;

   assign link_lo_al = {desc_i.link_lo[31:LINK_ALIGN], {LINK_ALIGN{1'b0}}};

   generate
      if (ADDR_W > 32) begin : g_wide
         assign buf_addr  = {desc_i.buf_hi[ADDR_W-33:0], desc_i.buf_lo};
         assign link_addr = {desc_i.link_hi[ADDR_W-33:0], link_lo_al};
      end else begin : g_narrow
         assign buf_addr  = desc_i.buf_lo[ADDR_W-1:0];
         assign link_addr = link_lo_al[ADDR_W-1:0];
      end
   endgenerate

   assign last_link    = desc_i.link_lo[LF_LAST];
   assign go_on        = (state_q == WK_STEP) && !last_link && !abort_q;
   assign busy_o       = (state_q != WK_IDLE);
   assign fetch_go_o   = ((state_q == WK_IDLE) && launch_i) || go_on;
   assign fetch_base_o = (state_q == WK_IDLE) ? head_i : link_addr;
   assign mv_valid_o   = (state_q == WK_MOVE);
   assign mv_addr_o    = buf_addr;
   assign mv_len_o     = desc_i.count;
   assign mv_to_host_o = desc_i.link_lo[LF_TOHOST];
   assign irq_evt_o    = (state_q == WK_STEP) && desc_i.link_lo[LF_IRQ] && !cut_q;
   assign credit_o     = (state_q == WK_MOVE) && mv_ack_i;
   assign credit_len_o = CNT_W'(desc_i.count);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         abort_q <= 1'b0;
         cut_q   <= 1'b0;
      end else begin
         if (abort_i && busy_o) abort_q <= 1'b1;
         unique case (state_q)
            WK_IDLE: begin
               if (launch_i) begin
                  state_q <= WK_FETCH;
                  abort_q <= 1'b0;
               end
            end
            WK_FETCH: begin
               if (fetch_done_i) begin
                  cut_q <= abort_q || abort_i;
                  if (abort_q || abort_i || desc_i.count == '0) state_q <= WK_STEP;
                  else                                          state_q <= WK_MOVE;
               end
            end
            WK_MOVE: begin
               if (mv_ack_i) begin
                  cut_q   <= 1'b0;
                  state_q <= WK_STEP;
               end
            end
            WK_STEP: begin
               state_q <= go_on ? WK_FETCH : WK_IDLE;
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   // R3: command held steady until the mover acknowledges it
   p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid_o && !mv_ack_i) |=> (mv_valid_o && $stable(mv_addr_o) && $stable(mv_len_o) && $stable(mv_to_host_o)));

   // R2: no command is presented while a descriptor is being read
   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_busy_i |-> !mv_valid_o);

   // R5: an end-of-chain descriptor returns the channel to idle
   p_last_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_STEP && last_link) |=> !busy_o);

   // R10: a pending abort ends the walk at the descriptor boundary
   p_abort_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_STEP && abort_q) |=> (!busy_o && !mv_valid_o));

   // R1: a launch always starts with a descriptor read
   p_launch_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WK_IDLE && launch_i) |=> fetch_busy_i);
endmodule

// File: rtl/sgd_regs.sv
module sgd_regs
   import sgd_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              busy_i,
   input  logic              credit_i,
   input  logic [CNT_W-1:0]  credit_len_i,
   input  logic              irq_evt_i,
   output logic              launch_o,
   output logic              abort_o,
   output logic [ADDR_W-1:0] head_o,
   output logic              irq_o
);
   logic [31:0]      ptr_lo_q;
   logic [31:0]      ptr_hi_q;
   logic             en_q;
   logic             sg_q;
   logic             irq_q;
   logic [CNT_W-1:0] bytes_q;
   logic             csr_wr;
   logic [31:0]      ptr_lo_al;

   assign csr_wr    = cfg_we && (cfg_sel == SEL_CSR);
   assign launch_o  = csr_wr && cfg_wdata[CS_EN] && cfg_wdata[CS_GO] && cfg_wdata[CS_SG] && !busy_i;
   assign abort_o   = csr_wr && cfg_wdata[CS_STOP] && busy_i;
   assign irq_o     = irq_q;
   assign ptr_lo_al = {ptr_lo_q[31:LINK_ALIGN], {LINK_ALIGN{1'b0}}};

   generate
      if (ADDR_W > 32) begin : g_head_wide
         assign head_o = {ptr_hi_q[ADDR_W-33:0], ptr_lo_al};
      end else begin : g_head_narrow
         assign head_o = ptr_lo_al[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_lo_q <= '0;
         ptr_hi_q <= '0;
         en_q     <= 1'b0;
         sg_q     <= 1'b0;
         irq_q    <= 1'b0;
         bytes_q  <= '0;
      end else begin
         if (cfg_we && cfg_sel == SEL_PTR_LO) ptr_lo_q <= cfg_wdata;
         if (cfg_we && cfg_sel == SEL_PTR_HI) ptr_hi_q <= cfg_wdata;
         if (csr_wr) begin
            en_q <= cfg_wdata[CS_EN];
            sg_q <= cfg_wdata[CS_SG];
         end
         if (irq_evt_i)                       irq_q <= 1'b1;
         else if (csr_wr && cfg_wdata[CS_IRQ]) irq_q <= 1'b0;
         if (launch_o)      bytes_q <= '0;
         else if (credit_i) bytes_q <= bytes_q + credit_len_i;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_sel)
         SEL_PTR_LO: cfg_rdata = ptr_lo_q;
         SEL_PTR_HI: cfg_rdata = ptr_hi_q;
         SEL_CSR: begin
            cfg_rdata[CS_EN]   = en_q;
            cfg_rdata[CS_IDLE] = !busy_i;
            cfg_rdata[CS_IRQ]  = irq_q;
            cfg_rdata[CS_SG]   = sg_q;
         end
         SEL_BYTES:  cfg_rdata = 32'(bytes_q);
         default:    cfg_rdata = '0;
      endcase
   end

   // R7: a launch leaves the byte total at zero
   p_bytes_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      launch_o |=> (bytes_q == '0));

   // R8: the interrupt bit only rises after a completion event
   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(irq_evt_i));
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
   import sgd_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              mv_valid,
   output logic [ADDR_W-1:0] mv_addr,
   output logic [31:0]       mv_len,
   output logic              mv_to_host,
   input  logic              mv_ack,
   output logic              irq
);
   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr_w
         $error("sgdma_walker: ADDR_W must lie in 32..64");
      end
      if (CNT_W < 16 || CNT_W > 32) begin : g_bad_cnt_w
         $error("sgdma_walker: CNT_W must lie in 16..32");
      end
   endgenerate

   logic              launch;
   logic              abort;
   logic [ADDR_W-1:0] head;
   logic              busy;
   logic              f_go;
   logic [ADDR_W-1:0] f_base;
   logic              f_busy;
   logic              f_done;
   sgd_desc_t         desc;
   logic              irq_evt;
   logic              credit;
   logic [CNT_W-1:0]  credit_len;

   sgd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .busy_i       (busy),
      .credit_i     (credit),
      .credit_len_i (credit_len),
      .irq_evt_i    (irq_evt),
      .launch_o     (launch),
      .abort_o      (abort),
      .head_o       (head),
      .irq_o        (irq)
   );

   sgd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (f_go),
      .base_i      (f_base),
      .mem_req_o   (mem_req),
      .mem_addr_o  (mem_addr),
      .mem_ack_i   (mem_ack),
      .mem_rdata_i (mem_rdata),
      .busy_o      (f_busy),
      .done_o      (f_done),
      .desc_o      (desc)
   );

   sgd_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_i     (launch),
      .head_i       (head),
      .abort_i      (abort),
      .busy_o       (busy),
      .fetch_go_o   (f_go),
      .fetch_base_o (f_base),
      .fetch_busy_i (f_busy),
      .fetch_done_i (f_done),
      .desc_i       (desc),
      .mv_valid_o   (mv_valid),
      .mv_addr_o    (mv_addr),
      .mv_len_o     (mv_len),
      .mv_to_host_o (mv_to_host),
      .mv_ack_i     (mv_ack),
      .irq_evt_o    (irq_evt),
      .credit_o     (credit),
      .credit_len_o (credit_len)
   );
endmodule

// File: tb/sgdma_walker_bench.sv
`timescale 1ns/1ps
module sgdma_walker_bench;
   localparam int ADDR_W = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [31:0]       cfg_wdata = '0;
   logic [31:0]       cfg_rdata;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ack;
   logic [31:0]       mem_rdata;
   logic              mv_valid;
   logic [ADDR_W-1:0] mv_addr;
   logic [31:0]       mv_len;
   logic              mv_to_host;
   logic              mv_ack;
   logic              irq;

   always #5 clk = ~clk;

   sgdma_walker #(.ADDR_W(ADDR_W), .CNT_W(32)) u_sgdma_walker (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mv_valid(mv_valid), .mv_addr(mv_addr), .mv_len(mv_len),
      .mv_to_host(mv_to_host), .mv_ack(mv_ack), .irq(irq)
   );

   // memory stub and read log
   logic [31:0] mem [256];
   logic [63:0] rd_log [1024];
   int          rd_n = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:2]];
         if (mem_req && mem_ack && rd_n < 1024) begin
            rd_log[rd_n] <= mem_addr;
            rd_n <= rd_n + 1;
         end
      end
   end

   // mover stub and command log
   logic        mv_hold = 1'b0;
   int          dly = 0;
   logic [63:0] c_addr [256];
   logic [31:0] c_len  [256];
   logic        c_dir  [256];
   int          cmd_n = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mv_ack <= 1'b0;
         dly    <= 0;
      end else begin
         mv_ack <= 1'b0;
         if (mv_valid && !mv_ack && !mv_hold) begin
            if (dly == 2) begin
               mv_ack <= 1'b1;
               dly    <= 0;
            end else dly <= dly + 1;
         end
         if (mv_valid && mv_ack && cmd_n < 256) begin
            c_addr[cmd_n] <= mv_addr;
            c_len[cmd_n]  <= mv_len;
            c_dir[cmd_n]  <= mv_to_host;
            cmd_n <= cmd_n + 1;
         end
      end
   end

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      cfg_sel = sel;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] v;
      int k;
      k = 0;
      v = '0;
      while (k < 3000) begin
         rd(2'd2, v);
         if (v[4]) break;
         k++;
      end
      chk(tag, {63'd0, v[4]}, 64'd1);
   endtask

   task automatic put_desc(input int a, input logic [63:0] bufa, input logic [31:0] cnt, input logic [63:0] link);
      int w;
      w = a >> 2;
      mem[w + 0] = bufa[31:0];
      mem[w + 1] = bufa[63:32];
      mem[w + 2] = 32'h5A5A_0000;
      mem[w + 3] = 32'h0;
      mem[w + 4] = cnt;
      mem[w + 5] = 32'h0;
      mem[w + 6] = link[31:0];
      mem[w + 7] = link[63:32];
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] cnt;
      logic        dir;
      logic        irqf;
      logic [1:0]  ecmd;
      logic [31:0] ebytes;
      logic        eirq;
   } row_t;

   localparam row_t TBL [4] = '{
      '{32'h1000_0000, 32'h0000_0100, 1'b0, 1'b0, 2'd1, 32'h0000_0100, 1'b0},
      '{32'h2000_0040, 32'h0000_0004, 1'b1, 1'b1, 2'd1, 32'h0000_0004, 1'b1},
      '{32'h3000_0080, 32'h0000_0000, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 1'b1},
      '{32'hFFFF_FFFC, 32'h0000_FFFC, 1'b1, 1'b0, 2'd1, 32'h0000_FFFC, 1'b0}
   };

   initial begin : watchdog
      #(10 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog act=hung exp=walk-complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [31:0] b1;
      int c0, r0, n_at;
      logic [63:0] hi_link;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      rd(2'd2, v);
      chk("R11 csr", {32'd0, v}, 64'h10);
      rd(2'd3, v);
      chk("R11 bytes", {32'd0, v}, 64'h0);
      chk("R11 irq pin", {63'd0, irq}, 64'd0);
      chk("R11 req/valid", {62'd0, mem_req, mv_valid}, 64'd0);

      // table of single-descriptor chains: R3 R5 R6 R7 R8
      for (int i = 0; i < 4; i++) begin
         hi_link = 64'h2 | (64'(TBL[i].dir) << 3) | (64'(TBL[i].irqf) << 2);
         put_desc(32'h40, {32'hA0 + 32'(i), TBL[i].addr}, TBL[i].cnt, hi_link);
         wr(2'd2, 32'h20);
         wr(2'd0, 32'h40);
         wr(2'd1, 32'h0);
         c0 = cmd_n; r0 = rd_n;
         wr(2'd2, 32'h103);
         wait_done("R5 done after end-of-chain");
         chk("R6/R3 command count", 64'(cmd_n - c0), 64'(TBL[i].ecmd));
         if (TBL[i].ecmd != 0) begin
            chk("R3 cmd addr", c_addr[c0], {32'hA0 + 32'(i), TBL[i].addr});
            chk("R3 cmd len", {32'd0, c_len[c0]}, {32'd0, TBL[i].cnt});
            chk("R3 cmd dir", {63'd0, c_dir[c0]}, {63'd0, TBL[i].dir});
         end
         rd(2'd3, v);
         chk("R7 bytes", {32'd0, v}, {32'd0, TBL[i].ebytes});
         rd(2'd2, v);
         chk("R8 irq bit", {63'd0, v[5]}, {63'd0, TBL[i].eirq});
         chk("R8 irq pin", {63'd0, irq}, {63'd0, TBL[i].eirq});
         if (i == 0) begin
            for (int k = 0; k < 8; k++)
               chk("R2 read order", rd_log[r0 + k], 64'h40 + 64'(4 * k));
         end
      end

      // R8: write-one clears interrupt
      wr(2'd2, 32'h20);
      rd(2'd2, v);
      chk("R8 w1c bit", {63'd0, v[5]}, 64'd0);
      chk("R8 w1c pin", {63'd0, irq}, 64'd0);

      // three-descriptor chain: R4 masking, R6 zero count, R2 order, R7 sum
      put_desc(32'h100, 64'h0000_0011_0000_1000, 32'h40, {32'h5, 32'h1C0 | 32'h19});
      put_desc(32'h1C0, 64'h0, 32'h0, {32'h0, 32'h080 | 32'h4});
      put_desc(32'h080, 64'h0000_0022_0000_2000, 32'h20, 64'h2);
      wr(2'd0, 32'h100 | 32'h1F);
      wr(2'd1, 32'h0);
      c0 = cmd_n; r0 = rd_n;
      wr(2'd2, 32'h103);
      wait_done("R5 chain done");
      chk("R6 chain cmds", 64'(cmd_n - c0), 64'd2);
      chk("R2 chain reads", 64'(rd_n - r0), 64'd24);
      chk("R2 head masked", rd_log[r0], 64'h100);
      chk("R4 link hi/masked", rd_log[r0 + 8], 64'h0000_0005_0000_01C0);
      chk("R4 third desc", rd_log[r0 + 16], 64'h80);
      chk("R3 dir bit3 set", {63'd0, c_dir[c0]}, 64'd1);
      chk("R3 dir bit3 clear", {63'd0, c_dir[c0 + 1]}, 64'd0);
      chk("R3 second addr", c_addr[c0 + 1], 64'h0000_0022_0000_2000);
      rd(2'd3, v);
      chk("R7 chain bytes", {32'd0, v}, 64'h60);
      chk("R8 zero-count irq", {63'd0, irq}, 64'd1);
      wr(2'd2, 32'h20);

      // R1: launch without scatter-gather mode is ignored
      r0 = rd_n;
      wr(2'd2, 32'h003);
      repeat (10) @(negedge clk);
      rd(2'd2, v);
      chk("R1 no-sg done", {63'd0, v[4]}, 64'd1);
      chk("R1 no-sg reads", 64'(rd_n - r0), 64'd0);

      // ring, launch-while-busy, abort: R9 R12 R10 R1
      put_desc(32'h200, 64'h0000_0001_0000_4000, 32'h8, 64'h220);
      put_desc(32'h220, 64'h0000_0001_0000_5000, 32'hC, 64'h200);
      wr(2'd0, 32'h200);
      wr(2'd1, 32'h0);
      c0 = cmd_n;
      wr(2'd2, 32'h103);
      rd(2'd2, v);
      chk("R1 busy done=0", {63'd0, v[4]}, 64'd0);
      begin
         int k;
         k = 0;
         while (cmd_n < c0 + 5 && k < 5000) begin @(negedge clk); k++; end
      end
      mv_hold = 1'b1;
      while (!mv_valid) @(negedge clk);
      rd(2'd3, b1);
      wr(2'd2, 32'h103);
      rd(2'd3, v);
      chk("R12 launch while busy", {32'd0, v}, {32'd0, b1});
      chk("R12 bytes nonzero", {63'd0, (v != 0)}, 64'd1);
      wr(2'd2, 32'h4);
      n_at = cmd_n;
      repeat (5) @(negedge clk);
      rd(2'd2, v);
      chk("R10 busy while cmd held", {63'd0, v[4]}, 64'd0);
      mv_hold = 1'b0;
      wait_done("R10 done after abort");
      chk("R10 in-flight completes only", 64'(cmd_n - n_at), 64'd1);
      chk("R9 ring kept cycling", {63'd0, (cmd_n - c0 > 5)}, 64'd1);
      begin
         int bad;
         logic [31:0] sum;
         bad = 0; sum = 0;
         for (int k = c0; k < cmd_n; k++) begin
            sum = sum + (((k - c0) % 2 == 0) ? 32'h8 : 32'hC);
            if (c_len[k] != (((k - c0) % 2 == 0) ? 32'h8 : 32'hC)) bad++;
            if (c_addr[k] != (((k - c0) % 2 == 0) ? 64'h1_0000_4000 : 64'h1_0000_5000)) bad++;
         end
         chk("R9 ring alternation", 64'(bad), 64'd0);
         rd(2'd3, v);
         chk("R7 ring bytes", {32'd0, v}, {32'd0, sum});
      end
      repeat (10) @(negedge clk);
      chk("R10 no later command", {63'd0, mv_valid}, 64'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule